// File: doc/BRIEF.md
# Local Interrupt Timer Register Window

This block is the register-facing slice of a per-processor interrupt controller, cut down to the identification words and a one-shot countdown timer. A host issues single-beat reads and writes on a plain strobe/address/data bus. Addresses are byte offsets inside a 4 KB page, and every access gets a response one cycle later, either with data or with an error flag.

The timer is started by loading an initial count. It then decrements once per count unit. A count unit is a number of base ticks set by the divide register, and a base tick is 16 core clocks. When the count reaches zero the block raises a one-cycle expiry pulse, unless the timer vector entry masks it. A count loaded part-way through a base tick waits for the next tick boundary before any counting begins. The remaining count can be read back at any time but cannot be written.

Top module: `lapic_timer_regs`

## Requirements
- R1: Reads of offset 0x20 return `PROC_ID << 24`. Reads of offset 0x30 return 0x00050014. Writes to either offset leave both values unchanged.
- R2: Every cycle with `req_valid` high is followed in the next cycle by exactly one cycle of `rsp_valid`. Read data and the error flag are valid in that cycle.
- R3: An access to a byte offset whose 8-byte slot (offset with bits 2:0 cleared) is not one of 0x20, 0x30, 0x320, 0x380, 0x390 or 0x3E0 responds with `rsp_err` = 1 and `rsp_rdata` = 0. Such a write changes no register.
- R4: The bytes `req_addr` through `req_addr + req_len` must fall in one 8-byte slot inside the page; `req_len` is the byte count minus one. An access that breaks this rule is an error as in R3, and a write that breaks it has no effect.
- R5: The divide register at 0x3E0 keeps only write-data bits 3, 1 and 0 and reads back with all other bits zero. The 3-bit code {b3,b1,b0} = 7 selects divide 1. Any other code v selects divide 2^(v+1).
- R6: Let edge 0 be the first rising clock edge with reset released, let the initial-count write at 0x380 be sampled at edge k, and let D = 16 × N × divide. If k mod 16 = 15, `timer_irq` is high in the cycle after edge k + D.
- R7: If k mod 16 is not 15, expiry is delayed to the cycle after edge k + D + 15 − (k mod 16). Counting starts only at the next tick boundary.
- R8: The expiry pulse lasts exactly one cycle. The current count then stays at zero until the next load.
- R9: While bit 16 of the timer vector entry (0x320) is set, the count still runs down to zero but `timer_irq` stays low.
- R10: Writing an initial count of zero stops a running timer at once, with no expiry pulse.
- R11: Offset 0x390 returns the remaining count in count units, which never increases except on a load. Writes to 0x390 are accepted without error and change nothing.
- R12: The timer vector entry resets to 0x00010000 (masked) and stores all 32 written bits. Offset 0x380 reads back the last initial count written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access strobe, one cycle per access |
| req_write | input | 1 | 1 for write, 0 for read |
| req_addr | input | 12 | Byte offset inside the page |
| req_len | input | 2 | Access size in bytes minus one |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response strobe, one cycle after the access |
| rsp_err | output | 1 | Reserved offset or slot-crossing access |
| rsp_rdata | output | 32 | Read data, zero on error and on writes |
| timer_irq | output | 1 | One-cycle timer expiry pulse |

## Verification
The bench sweeps the start phase of the timer across the base tick, for every divide code and several counts. A design that counts the partial first tick fires up to 15 cycles early. A design that ignores the divide fires at the wrong multiple of 16. Every 8-byte slot of the page is probed, along with accesses that cross a slot or the page end, so a decoder that matches on too few address bits, or that lets a crossing write through, is caught by a wrong error flag or by a timer that starts. The bench also covers masked expiry, stopping with a zero load, and writes to the read-only count. These catch a pulse that leaks through the mask, a stray pulse on stop, and a current count that takes a write.

// File: rtl/lapic_timer_regs.sv
module lapic_timer_regs #(
  parameter int PROC_ID = 3,
  parameter int PRE_W   = 4,
  parameter int DIV_W   = 7
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic        req_write,
  input  logic [11:0] req_addr,
  input  logic [1:0]  req_len,
  input  logic [31:0] req_wdata,
  output logic        rsp_valid,
  output logic        rsp_err,
  output logic [31:0] rsp_rdata,
  output logic        timer_irq
);
  localparam logic [11:0] OFS_ID   = 12'h020;
  localparam logic [11:0] OFS_VER  = 12'h030;
  localparam logic [11:0] OFS_VEC  = 12'h320;
  localparam logic [11:0] OFS_ICNT = 12'h380;
  localparam logic [11:0] OFS_CCNT = 12'h390;
  localparam logic [11:0] OFS_DIV  = 12'h3E0;
  localparam logic [31:0] VER_VAL  = 32'h0005_0014;

  logic [31:0]      vec_q, icnt_q, cnt_q;
  logic [2:0]       dcode_q;
  logic [PRE_W-1:0] pre_q;
  logic [DIV_W-1:0] dcnt_q;
  logic             armed_q;

  logic [11:0] slot;
  logic [12:0] last_b;
  logic        crosses, mapped, acc_ok, ld, wr_vec, wr_div;
  logic        tick, unit;
  logic [DIV_W-1:0] div_m1;
  logic [31:0] rd_mux;

  assign slot    = {req_addr[11:3], 3'b000};
  assign last_b  = {1'b0, req_addr} + {11'd0, req_len};
  assign crosses = last_b[12:3] != {1'b0, req_addr[11:3]};

  always_comb begin
    mapped = 1'b1;
    rd_mux = 32'd0;
    case (slot)
      OFS_ID:   rd_mux = 32'(PROC_ID) << 24;
      OFS_VER:  rd_mux = VER_VAL;
      OFS_VEC:  rd_mux = vec_q;
      OFS_ICNT: rd_mux = icnt_q;
      OFS_CCNT: rd_mux = cnt_q;
      OFS_DIV:  rd_mux = {28'd0, dcode_q[2], 1'b0, dcode_q[1:0]};
      default:  mapped = 1'b0;
    endcase
  end

  assign acc_ok = req_valid && mapped && !crosses;
  assign ld     = acc_ok && req_write && slot == OFS_ICNT;
  assign wr_vec = acc_ok && req_write && slot == OFS_VEC;
  assign wr_div = acc_ok && req_write && slot == OFS_DIV;

  assign div_m1 = (dcode_q == 3'b111) ? '0 : DIV_W'((9'd2 << dcode_q) - 9'd1);
  assign tick   = &pre_q;
  assign unit   = tick && armed_q && dcnt_q >= div_m1 && cnt_q != 0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= req_valid;
      rsp_err   <= req_valid && !(mapped && !crosses);
      rsp_rdata <= (acc_ok && !req_write) ? rd_mux : '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vec_q   <= 32'h0001_0000;
      icnt_q  <= '0;
      dcode_q <= '0;
    end else begin
      if (wr_vec) vec_q <= req_wdata;
      if (ld) icnt_q <= req_wdata;
      if (wr_div) dcode_q <= {req_wdata[3], req_wdata[1], req_wdata[0]};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pre_q     <= '0;
      dcnt_q    <= '0;
      armed_q   <= 1'b0;
      cnt_q     <= '0;
      timer_irq <= 1'b0;
    end else begin
      pre_q     <= pre_q + 1'b1;
      timer_irq <= 1'b0;
      if (ld) begin
        cnt_q   <= req_wdata;
        dcnt_q  <= '0;
        armed_q <= tick;
      end else if (tick && cnt_q != 0) begin
        if (!armed_q) begin
          armed_q <= 1'b1;
        end else if (unit) begin
          dcnt_q    <= '0;
          cnt_q     <= cnt_q - 1'b1;
          timer_irq <= (cnt_q == 32'd1) && !vec_q[16];
        end else begin
          dcnt_q <= dcnt_q + 1'b1;
        end
      end
    end
  end

  p_rsp_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  p_rsp_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);
  p_err_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> (rsp_rdata == 32'd0 && rsp_valid));
  p_pulse_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    timer_irq |=> !timer_irq);
  p_irq_at_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    timer_irq |-> cnt_q == 32'd0);
  p_mask_r9: assert property (@(posedge clk) disable iff (!rst_n)
    timer_irq |-> !$past(vec_q[16]));
  p_zero_load_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ld && req_wdata == 32'd0) |=> !timer_irq);
  p_count_down_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !ld |=> cnt_q <= $past(cnt_q));
endmodule

// File: tb/test_lapic_timer_regs.sv
module test_lapic_timer_regs;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [11:0] req_addr = '0;
  logic [1:0]  req_len = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid, rsp_err, timer_irq;
  logic [31:0] rsp_rdata;

  int checks = 0;
  int errors = 0;
  int ecnt = 0;

  lapic_timer_regs #(.PROC_ID(3)) i_lapic_timer_regs (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_len(req_len), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
    .timer_irq(timer_irq));

  always #2.5 clk = ~clk;
  always @(posedge clk) if (rst_n) ecnt <= ecnt + 1;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic access(input logic wr, input logic [11:0] a, input logic [1:0] len,
                        input logic [31:0] wd, output logic [31:0] rd, output logic er);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_len = len; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    check("R2 rsp_valid", {31'd0, rsp_valid}, 32'd1);
    rd = rsp_rdata;
    er = rsp_err;
  endtask

  task automatic rd_chk(input string req, input logic [11:0] a, input logic [31:0] exp);
    logic [31:0] d; logic e;
    access(1'b0, a, 2'd3, 32'd0, d, e);
    check(req, {31'd0, e}, 32'd0);
    check(req, d, exp);
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] v);
    logic [31:0] d; logic e;
    access(1'b1, a, 2'd3, v, d, e);
  endtask

  task automatic run_timer(input int code, input int n, input int phase);
    int dv, dexp, d;
    logic saw;
    dv = (code == 7) ? 1 : (2 << code);
    wr(12'h3E0, {28'd0, code[2], 1'b0, code[1:0]});
    while ((ecnt % 16) != phase) @(negedge clk);
    dexp = 16 * n * dv + ((phase == 15) ? 0 : 15 - phase);
    wr(12'h380, n);
    d = 0;
    while (!timer_irq && d < dexp + 40) begin
      @(negedge clk);
      d++;
    end
    if (phase == 15) check("R6 expiry cycles", d, dexp);
    else check("R7 misaligned expiry cycles", d, dexp);
    @(negedge clk);
    check("R8 pulse one cycle", {31'd0, timer_irq}, 32'd0);
    rd_chk("R8 count held at zero", 12'h390, 32'd0);
  endtask

  initial begin
    #900000;
    errors++;
    $display("FAIL watchdog: run did not complete");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic e;
    logic exp_map;
    logic saw;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check("R2 no response after reset", {31'd0, rsp_valid}, 32'd0);
    check("R8 no pulse after reset", {31'd0, timer_irq}, 32'd0);

    rd_chk("R1 id", 12'h020, 32'h0300_0000);
    rd_chk("R1 version", 12'h030, 32'h0005_0014);
    rd_chk("R12 vector reset", 12'h320, 32'h0001_0000);
    rd_chk("R12 initial count reset", 12'h380, 32'd0);
    rd_chk("R11 current count reset", 12'h390, 32'd0);
    rd_chk("R5 divide reset", 12'h3E0, 32'd0);

    for (int s = 0; s < 512; s++) begin
      logic [11:0] a;
      a = 12'(s * 8);
      exp_map = (a == 12'h020 || a == 12'h030 || a == 12'h320 ||
                 a == 12'h380 || a == 12'h390 || a == 12'h3E0);
      access(1'b0, a + 12'd4, 2'd3, 32'd0, d, e);
      check("R3 error flag sweep", {31'd0, e}, {31'd0, !exp_map});
      if (!exp_map) check("R3 error data zero", d, 32'd0);
    end

    wr(12'h3E8, 32'h0000_000F);
    rd_chk("R3 unmapped write ignored", 12'h3E0, 32'd0);

    access(1'b0, 12'h386, 2'd3, 32'd0, d, e);
    check("R4 crossing read error", {31'd0, e}, 32'd1);
    check("R4 crossing read data", d, 32'd0);
    access(1'b0, 12'h024, 2'd3, 32'd0, d, e);
    check("R4 in-slot read ok", {31'd0, e}, 32'd0);
    check("R4 in-slot read data", d, 32'h0300_0000);
    access(1'b0, 12'hFFE, 2'd3, 32'd0, d, e);
    check("R4 page end crossing", {31'd0, e}, 32'd1);
    access(1'b1, 12'h385, 2'd3, 32'd5, d, e);
    check("R4 crossing write error", {31'd0, e}, 32'd1);
    rd_chk("R4 crossing write ignored", 12'h380, 32'd0);
    rd_chk("R4 timer not started", 12'h390, 32'd0);

    access(1'b1, 12'h390, 2'd3, 32'h0000_1234, d, e);
    check("R11 count write accepted", {31'd0, e}, 32'd0);
    rd_chk("R11 count write ignored", 12'h390, 32'd0);
    wr(12'h020, 32'd0);
    rd_chk("R1 id write ignored", 12'h020, 32'h0300_0000);
    wr(12'h030, 32'd0);
    rd_chk("R1 version write ignored", 12'h030, 32'h0005_0014);

    for (int v = 0; v < 16; v++) begin
      wr(12'h3E0, 32'hFFFF_FFF0 | 32'(v));
      rd_chk("R5 divide readback", 12'h3E0, 32'(v) & 32'hB);
    end

    wr(12'h320, 32'h0000_0030);
    rd_chk("R12 vector write", 12'h320, 32'h0000_0030);

    for (int c = 0; c < 8; c++)
      for (int n = 1; n <= 2; n++) begin
        run_timer(c, n, 15);
        run_timer(c, n, (c * 5 + n * 3) % 15);
      end
    run_timer(7, 3, 0);
    run_timer(0, 3, 7);
    rd_chk("R12 initial count readback", 12'h380, 32'd3);

    wr(12'h3E0, 32'h0000_000B);
    while ((ecnt % 16) != 15) @(negedge clk);
    wr(12'h380, 32'd5);
    rd_chk("R11 count right after load", 12'h390, 32'd5);
    repeat (37) @(negedge clk);
    rd_chk("R11 count mid run", 12'h390, 32'd3);

    wr(12'h320, 32'h0001_0030);
    wr(12'h380, 32'd2);
    saw = 1'b0;
    repeat (80) begin
      @(negedge clk);
      if (timer_irq) saw = 1'b1;
    end
    check("R9 masked no pulse", {31'd0, saw}, 32'd0);
    rd_chk("R9 masked count reached zero", 12'h390, 32'd0);

    wr(12'h320, 32'h0000_0030);
    wr(12'h380, 32'd100);
    repeat (40) @(negedge clk);
    wr(12'h380, 32'd0);
    saw = 1'b0;
    repeat (2000) begin
      @(negedge clk);
      if (timer_irq) saw = 1'b1;
    end
    check("R10 zero load no pulse", {31'd0, saw}, 32'd0);
    rd_chk("R10 zero load stops", 12'h390, 32'd0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule